// File: doc/BRIEF.md
# Pointer Justification Event Counter

This block tallies the positive and negative pointer justification events reported for three received tributaries. Every tributary has two running counters, one for increments and one for decrements. Each running counter has a holding register that a host reads. A performance-monitoring strobe moves each running count into its holding register and starts a new interval.

When a tributary loses its pointer or receives path AIS, its running counters and its holding registers are forced to zero. Events that arrive during loss of pointer are not counted. A single mode input sets the behaviour at the top of the 11-bit range: the count either stops at 2047 or wraps to zero.

Top module: `ptrjust_counter`

## Requirements
- R1: While `rst_n` is low, every holding register reads 0.
- R2: An increment pulse and a decrement pulse on the same tributary in the same cycle are each counted, each in its own counter.
- R3: A cycle with `pm_strobe` high and no clear copies the running count into the holding register. The copy is visible one cycle later. Tributary t occupies bits [t*11 +: 11] of `inc_hold` and of `dec_hold`.
- R4: After a strobe the running count restarts at 0. An event in the strobe cycle counts toward the new interval, so the next strobe reports at least 1.
- R5: A holding register keeps its value in every cycle that has neither a strobe nor a clear of its tributary.
- R6: A cycle with `lop[t]` or `ais[t]` high zeroes both holding registers and both running counts of tributary t from the next cycle on.
- R7: Event pulses on a tributary whose `lop` bit is high are not counted.
- R8: With `sat_mode` = 1, a running count at 2047 stays at 2047 on further events.
- R9: With `sat_mode` = 0, an event at 2047 gives 0, and counting then goes on from there.
- R10: The tributaries are independent. Events, strobe effects and clears on one tributary leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_evt | input | 3 | Per-tributary pointer increment pulse |
| dec_evt | input | 3 | Per-tributary pointer decrement pulse |
| lop | input | 3 | Per-tributary loss-of-pointer state |
| ais | input | 3 | Per-tributary path AIS state |
| pm_strobe | input | 1 | Performance-monitoring interval strobe, one cycle |
| sat_mode | input | 1 | 1 = saturate at maximum, 0 = wrap |
| inc_hold | output | 33 | Latched increment counts, 11 bits per tributary |
| dec_hold | output | 33 | Latched decrement counts, 11 bits per tributary |

## Verification
The assertions take `pm_strobe`, `lop` and `ais` to be synchronous to `clk` and free of unknown values once reset is released. The hold-stability property relies on the strobe and the two state inputs being the only inputs that may move a holding register. The random stimulus drives every input from the bench at the falling edge, so each value is settled one half period before the edge that samples it. It raises `lop` and `ais` only rarely and keeps the strobe interval long, so that hold values are checked across long stretches of stable cycles.

// File: rtl/ptrjust_pkg.sv
package ptrjust_pkg;
    localparam int unsigned PJ_NUM_TRIB = 3;
    localparam int unsigned PJ_CNT_W    = 11;

    typedef enum logic {
        TOP_WRAP = 1'b0,
        TOP_SAT  = 1'b1
    } top_mode_e;
endpackage

// File: rtl/ptrjust_cell.sv
module ptrjust_cell #(
    parameter int unsigned CNT_W = ptrjust_pkg::PJ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    input  logic             strobe,
    input  logic             sat_mode,
    output logic [CNT_W-1:0] hold
);
    import ptrjust_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hold;
    } cell_state_t;

    cell_state_t st_d, st_q;
    top_mode_e   mode;

    assign mode = top_mode_e'(sat_mode);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.run  = '0;
            st_d.hold = '0;
        end else if (strobe) begin
            st_d.hold = st_q.run;
            st_d.run  = evt ? CNT_ONE : '0;
        end else if (evt) begin
            if (st_q.run == CNT_MAX) begin
                st_d.run = (mode == TOP_SAT) ? CNT_MAX : '0;
            end else begin
                st_d.run = st_q.run + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;
endmodule

// File: rtl/ptrjust_lane.sv
module ptrjust_lane #(
    parameter int unsigned CNT_W = ptrjust_pkg::PJ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_evt,
    input  logic             dec_evt,
    input  logic             lop,
    input  logic             ais,
    input  logic             strobe,
    input  logic             sat_mode,
    output logic [CNT_W-1:0] inc_hold,
    output logic [CNT_W-1:0] dec_hold
);
    localparam int unsigned N_KIND = 2;

    logic                       clr;
    logic [N_KIND-1:0]          evt_ok;
    logic [N_KIND-1:0]          evt_raw;
    logic [N_KIND-1:0][CNT_W-1:0] holds;

    // Loss of pointer and AIS both clear; events during LOP are dropped.
    assign clr     = lop | ais;
    assign evt_raw = {dec_evt, inc_evt};
    assign evt_ok  = evt_raw & {N_KIND{~lop}};

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        ptrjust_cell #(.CNT_W(CNT_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_ok[k]),
            .clr      (clr),
            .strobe   (strobe),
            .sat_mode (sat_mode),
            .hold     (holds[k])
        );
    end

    assign inc_hold = holds[0];
    assign dec_hold = holds[1];
endmodule

// File: rtl/ptrjust_counter.sv
module ptrjust_counter #(
    parameter int unsigned NUM_TRIB = ptrjust_pkg::PJ_NUM_TRIB,
    parameter int unsigned CNT_W    = ptrjust_pkg::PJ_CNT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_TRIB-1:0]       inc_evt,
    input  logic [NUM_TRIB-1:0]       dec_evt,
    input  logic [NUM_TRIB-1:0]       lop,
    input  logic [NUM_TRIB-1:0]       ais,
    input  logic                      pm_strobe,
    input  logic                      sat_mode,
    output logic [NUM_TRIB*CNT_W-1:0] inc_hold,
    output logic [NUM_TRIB*CNT_W-1:0] dec_hold
);
    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
        ptrjust_lane #(.CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_evt  (inc_evt[t]),
            .dec_evt  (dec_evt[t]),
            .lop      (lop[t]),
            .ais      (ais[t]),
            .strobe   (pm_strobe),
            .sat_mode (sat_mode),
            .inc_hold (inc_hold[t*CNT_W +: CNT_W]),
            .dec_hold (dec_hold[t*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/ptrjust_counter_chk.sv
module ptrjust_counter_chk #(
    parameter int unsigned NUM_TRIB = 3,
    parameter int unsigned CNT_W    = 11
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_TRIB-1:0]       lop,
    input logic [NUM_TRIB-1:0]       ais,
    input logic                      pm_strobe,
    input logic [NUM_TRIB*CNT_W-1:0] inc_hold,
    input logic [NUM_TRIB*CNT_W-1:0] dec_hold
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (inc_hold == '0 && dec_hold == '0));

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_t
        // R6
        inc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lop[t] || ais[t]) |=> inc_hold[t*CNT_W +: CNT_W] == '0);
        // R6
        dec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lop[t] || ais[t]) |=> dec_hold[t*CNT_W +: CNT_W] == '0);
        // R5
        inc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pm_strobe && !lop[t] && !ais[t]) |=> $stable(inc_hold[t*CNT_W +: CNT_W]));
        // R5
        dec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pm_strobe && !lop[t] && !ais[t]) |=> $stable(dec_hold[t*CNT_W +: CNT_W]));
    end
endmodule

bind ptrjust_counter ptrjust_counter_chk #(.NUM_TRIB(NUM_TRIB), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lop       (lop),
    .ais       (ais),
    .pm_strobe (pm_strobe),
    .inc_hold  (inc_hold),
    .dec_hold  (dec_hold)
);

// File: tb/test_ptrjust_counter.sv
module test_ptrjust_counter;
    localparam int NT = 3;
    localparam int CW = 11;
    localparam logic [CW-1:0] MAXV = 11'd2047;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] inc_evt = '0, dec_evt = '0, lop = '0, ais = '0;
    logic pm_strobe = 1'b0, sat_mode = 1'b0;
    logic [NT*CW-1:0] inc_hold, dec_hold;

    int n_chk = 0, n_bad = 0;
    logic [CW-1:0] m_run_i [NT], m_run_d [NT], m_hold_i [NT], m_hold_d [NT];

    always #4 clk = ~clk;

    ptrjust_counter i_ptrjust_counter (
        .clk(clk), .rst_n(rst_n), .inc_evt(inc_evt), .dec_evt(dec_evt),
        .lop(lop), .ais(ais), .pm_strobe(pm_strobe), .sat_mode(sat_mode),
        .inc_hold(inc_hold), .dec_hold(dec_hold)
    );

    function automatic logic [CW-1:0] bump(logic [CW-1:0] r, logic e, logic s);
        if (!e) return r;
        if (r == MAXV) return s ? MAXV : '0;
        return r + 1'b1;
    endfunction

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        for (int t = 0; t < NT; t++) begin
            check(tag, inc_hold[t*CW +: CW], m_hold_i[t]);
            check(tag, dec_hold[t*CW +: CW], m_hold_d[t]);
        end
    endtask

    // drive at negedge, update the model at posedge, compare at the next negedge
    task automatic step(logic [NT-1:0] i, logic [NT-1:0] d, logic [NT-1:0] l,
                        logic [NT-1:0] a, logic s, logic m, string tag);
        inc_evt = i; dec_evt = d; lop = l; ais = a; pm_strobe = s; sat_mode = m;
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            logic ei, ed;
            ei = i[t] & ~l[t];
            ed = d[t] & ~l[t];
            if (l[t] | a[t]) begin
                m_run_i[t] = '0; m_run_d[t] = '0; m_hold_i[t] = '0; m_hold_d[t] = '0;
            end else if (s) begin
                m_hold_i[t] = m_run_i[t]; m_hold_d[t] = m_run_d[t];
                m_run_i[t] = ei ? 11'd1 : '0; m_run_d[t] = ed ? 11'd1 : '0;
            end else begin
                m_run_i[t] = bump(m_run_i[t], ei, m);
                m_run_d[t] = bump(m_run_d[t], ed, m);
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(int n, logic m, string tag);
        for (int k = 0; k < n; k++) step('0, '0, '0, '0, 1'b0, m, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int t = 0; t < NT; t++) begin
            m_run_i[t] = '0; m_run_d[t] = '0; m_hold_i[t] = '0; m_hold_d[t] = '0;
        end
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: simultaneous inc and dec on tributary 0
        for (int k = 0; k < 3; k++) step(3'b001, 3'b001, '0, '0, 1'b0, 1'b1, "R2");
        for (int k = 0; k < 2; k++) step(3'b001, '0, '0, '0, 1'b0, 1'b1, "R2");
        step('0, '0, '0, '0, 1'b1, 1'b1, "R3");
        check("R2", inc_hold[0 +: CW], 11'd5);
        check("R2", dec_hold[0 +: CW], 11'd3);

        // R4: event in strobe cycle belongs to the new interval
        step(3'b010, '0, '0, '0, 1'b1, 1'b1, "R4");
        check("R4", inc_hold[0 +: CW], 11'd0);
        idle(2, 1'b1, "R5");
        check("R5", inc_hold[0 +: CW], 11'd0);
        step('0, '0, '0, '0, 1'b1, 1'b1, "R4");
        check("R4", inc_hold[CW +: CW], 11'd1);

        // R6: AIS on tributary 1 clears it, R10: others untouched
        for (int k = 0; k < 4; k++) step(3'b111, 3'b111, '0, '0, 1'b0, 1'b1, "R10");
        step('0, '0, '0, '0, 1'b1, 1'b1, "R3");
        step('0, '0, '0, 3'b010, 1'b0, 1'b1, "R6");
        check("R6", inc_hold[CW +: CW], 11'd0);
        check("R10", inc_hold[2*CW +: CW], 11'd4);

        // R7: events during LOP are dropped
        for (int k = 0; k < 5; k++) step(3'b100, 3'b100, 3'b100, '0, 1'b0, 1'b1, "R7");
        step(3'b100, '0, '0, '0, 1'b0, 1'b1, "R7");
        step(3'b100, '0, '0, '0, 1'b0, 1'b1, "R7");
        step('0, '0, '0, '0, 1'b1, 1'b1, "R7");
        check("R7", inc_hold[2*CW +: CW], 11'd2);
        check("R7", dec_hold[2*CW +: CW], 11'd0);

        // R8: saturate
        for (int k = 0; k < 2050; k++) step(3'b001, '0, '0, '0, 1'b0, 1'b1, "R8");
        step('0, '0, '0, '0, 1'b1, 1'b1, "R8");
        check("R8", inc_hold[0 +: CW], MAXV);

        // R9: wrap
        for (int k = 0; k < 2049; k++) step('0, 3'b010, '0, '0, 1'b0, 1'b0, "R9");
        step('0, '0, '0, '0, 1'b1, 1'b0, "R9");
        check("R9", dec_hold[CW +: CW], 11'd1);

        // R3: constrained random mix
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int k = 0; k < 4000; k++) begin
            logic [NT-1:0] ri, rd, rl, ra;
            logic rs, rm;
            ri = NT'($urandom) & NT'($urandom);
            rd = NT'($urandom) & NT'($urandom);
            rl = '0; ra = '0;
            for (int t = 0; t < NT; t++) begin
                rl[t] = ($urandom_range(0, 99) < 2);
                ra[t] = ($urandom_range(0, 99) < 1);
            end
            rs = ($urandom_range(0, 29) == 0);
            rm = (k < 2000);
            step(ri, rd, rl, ra, rs, rm, "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule